// File: doc/BRIEF.md
# Register Window to Legacy Display Port Bridge

This block sits behind a 4 KiB memory-mapped register window and forwards host accesses to the display controller's older register interfaces. One part of the window reaches a bus of 32 legacy 8-bit display I/O ports. A second part reaches a 16-bit indexed register interface: the block writes the register number first and then moves the data. A third part holds two 32-bit extension registers, and one of them selects the framebuffer byte order.

The host side is a plain request/response bus. A request carries a 12-bit window offset, an access size of 1, 2 or 4 bytes, a write flag and 32 bits of write data. The host holds the request until the block returns a one-cycle ready pulse, which comes with the read data. Internally a sequencer breaks each wide access into single-byte port transfers, always lowest byte first. Because of this order, an index/data port pair can be loaded with one 16-bit store. The sequencer also collects read bytes back into one word. Each downstream transfer is a one-cycle strobe, and the transfer completes when the responder raises ready.

Top module: `mmio_vga_bridge`

## Requirements
- R1: An access of 1, 2 or 4 bytes that lies entirely within offsets 0x400..0x41F becomes byte transfers on the port bus. Window offset 0x400+N addresses port 0x3C0+N, so the ports covered are 0x3C0..0x3DF.
- R2: A 2-byte write at offset 0x400+N issues two port writes. The first writes wdata[7:0] to port 0x3C0+N. The second writes wdata[15:8] to port 0x3C1+N.
- R3: On a port read, the byte from the k-th transfer (k = 0..3) lands in rdata[8k+7:8k]. Bits above the access size read as zero.
- R4: A 4-byte port access issues four byte transfers to ports 0x3C0+N through 0x3C3+N, in ascending order.
- R5: An access of 1, 2 or 4 bytes that lies entirely within offsets 0x500..0x515 runs two transfers. First comes an index write whose data is (offset-0x500)>>1, marked by the index flag. Then comes one 16-bit data transfer. A write sends wdata[15:0]. A read returns the 16-bit data zero-extended.
- R6: When the extension registers are enabled, a 4-byte read at offset 0x600 returns 8. Any access to 0x600 or 0x604 whose size is not 4 is treated as unmapped.
- R7: A 4-byte read at offset 0x604 returns 0xBEBEBEBE when big-endian is selected and 0x1E1E1E1E when little-endian is selected. The big_endian output reflects the same setting.
- R8: A 4-byte write to offset 0x604 of exactly 0xBEBEBEBE selects big-endian. A write of exactly 0x1E1E1E1E selects little-endian. A write of any other value leaves the setting unchanged.
- R9: The extension registers respond only while xreg_en is 1. While xreg_en is 0 they behave as unmapped. The revision output is 2 while xreg_en is 1 and 1 otherwise.
- R10: Any other access reads as zero and completes without a downstream strobe. This includes unmapped offsets, accesses that run past the end of a region, and sizes other than 1, 2 or 4. A write of this kind changes nothing.
- R11: req_ready is a single-cycle pulse that follows the last downstream transfer. Each strobe lasts one cycle and waits for its ready. The port strobe and the indexed-interface strobe are never active together.
- R12: After reset the sequencer is idle, no strobe or ready is active, and little-endian is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the window |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, little-endian byte lanes |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, valid with req_ready |
| port_stb | output | 1 | Port transfer strobe |
| port_we | output | 1 | Port transfer is a write |
| port_addr | output | 10 | Port number 0x3C0..0x3DF |
| port_wdata | output | 8 | Port write byte |
| port_rdata | input | 8 | Port read byte, valid with port_rdy |
| port_rdy | input | 1 | Port transfer complete |
| dx_stb | output | 1 | Indexed-interface strobe |
| dx_index | output | 1 | 1 = index write, 0 = data transfer |
| dx_we | output | 1 | Transfer is a write |
| dx_wdata | output | 16 | Index or write data |
| dx_rdata | input | 16 | Read data, valid with dx_rdy |
| dx_rdy | input | 1 | Indexed transfer complete |
| xreg_en | input | 1 | Enables the extension registers |
| big_endian | output | 1 | Selected framebuffer byte order |
| revision | output | 8 | 2 with extensions enabled, else 1 |

## Verification
The assertions assume that the host keeps req_valid and its fields steady until req_ready and drops req_valid in the cycle after the pulse. They also assume that each responder raises ready only for a strobe it has seen. The bench enforces both rules: its driver releases the request on the same falling edge at which it sees req_ready. Its responders answer only strobes that have been issued, after a programmable delay of zero or more cycles. Because of this, the byte-order check and the one-strobe-at-a-time check hold no matter which access order a test case uses.

// File: rtl/mmio_vga_bridge.sv
module mmio_vga_bridge #(
  parameter int LEG_BASE  = 12'h400,
  parameter int LEG_SPAN  = 32,
  parameter int PORT_BASE = 10'h3C0,
  parameter int DX_BASE   = 12'h500,
  parameter int DX_SPAN   = 22,
  parameter int QX_BASE   = 12'h600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic [31:0] req_rdata,
  output logic        port_stb,
  output logic        port_we,
  output logic [9:0]  port_addr,
  output logic [7:0]  port_wdata,
  input  logic [7:0]  port_rdata,
  input  logic        port_rdy,
  output logic        dx_stb,
  output logic        dx_index,
  output logic        dx_we,
  output logic [15:0] dx_wdata,
  input  logic [15:0] dx_rdata,
  input  logic        dx_rdy,
  input  logic        xreg_en,
  output logic        big_endian,
  output logic [7:0]  revision
);
  localparam logic [12:0] LEG_END = 13'(LEG_BASE + LEG_SPAN - 1);
  localparam logic [12:0] DX_END  = 13'(DX_BASE + DX_SPAN - 1);
  localparam logic [31:0] MAGIC_BE = 32'hBEBEBEBE;
  localparam logic [31:0] MAGIC_LE = 32'h1E1E1E1E;

  typedef enum logic [2:0] {S_IDLE, S_LEG, S_DXI, S_DXD, S_RESP} state_t;
  state_t st;

  logic [1:0]  cnt, lastc;
  logic [4:0]  off, idx;
  logic        wr, ps, ds, di, be;
  logic [31:0] wd, rd;

  logic [12:0] a_end;
  logic        size_ok, hit_leg, hit_dx, hit_qx;
  logic [11:0] loff, doff;
  logic [31:0] qx_val;

  assign a_end   = {1'b0, req_addr} + {10'b0, req_size} - 13'd1;
  assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  assign hit_leg = size_ok && ({1'b0, req_addr} >= 13'(LEG_BASE)) && (a_end <= LEG_END);
  assign hit_dx  = size_ok && ({1'b0, req_addr} >= 13'(DX_BASE)) && (a_end <= DX_END);
  assign hit_qx  = xreg_en && (req_size == 3'd4) &&
                   ((req_addr == 12'(QX_BASE)) || (req_addr == 12'(QX_BASE + 4)));
  assign loff    = req_addr - 12'(LEG_BASE);
  assign doff    = req_addr - 12'(DX_BASE);
  assign qx_val  = req_addr[2] ? (be ? MAGIC_BE : MAGIC_LE) : 32'd8;

  assign req_ready  = (st == S_RESP);
  assign req_rdata  = rd;
  assign port_stb   = ps;
  assign port_we    = wr;
  assign port_addr  = 10'(PORT_BASE) + {5'b0, off} + {8'b0, cnt};
  assign port_wdata = wd[{cnt, 3'b000} +: 8];
  assign dx_stb     = ds;
  assign dx_index   = di;
  assign dx_we      = di | wr;
  assign dx_wdata   = di ? {11'b0, idx} : wd[15:0];
  assign big_endian = be;
  assign revision   = xreg_en ? 8'd2 : 8'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ps <= 1'b0; ds <= 1'b0; di <= 1'b0; be <= 1'b0;
      cnt <= '0; lastc <= '0; off <= '0; idx <= '0; wr <= 1'b0;
      wd <= '0; rd <= '0;
    end else begin
      ps <= 1'b0;
      ds <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr <= req_write; wd <= req_wdata; cnt <= '0; rd <= '0;
          if (hit_leg) begin
            off <= loff[4:0]; lastc <= 2'(req_size - 3'd1); ps <= 1'b1; st <= S_LEG;
          end else if (hit_dx) begin
            idx <= doff[5:1]; di <= 1'b1; ds <= 1'b1; st <= S_DXI;
          end else begin
            st <= S_RESP;
            if (hit_qx) begin
              if (!req_write) rd <= qx_val;
              else if (req_addr[2] && req_wdata == MAGIC_BE) be <= 1'b1;
              else if (req_addr[2] && req_wdata == MAGIC_LE) be <= 1'b0;
            end
          end
        end
        S_LEG: if (port_rdy) begin
          rd[{cnt, 3'b000} +: 8] <= port_rdata;
          if (cnt == lastc) st <= S_RESP;
          else begin cnt <= cnt + 2'd1; ps <= 1'b1; end
        end
        S_DXI: if (dx_rdy) begin
          di <= 1'b0; ds <= 1'b1; st <= S_DXD;
        end
        S_DXD: if (dx_rdy) begin
          rd <= {16'b0, dx_rdata}; st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_one_bus_r11: assert property (@(posedge clk) disable iff (!rst_n) !(port_stb && dx_stb));
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) req_ready |=> !req_ready);
  p_port_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    port_stb |-> (port_addr >= 10'h3C0 && port_addr <= 10'h3DF));
  p_index_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_stb && !dx_index) |-> $past(dx_index));
  p_order_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(big_endian));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && !port_stb && !dx_stb && !req_ready && !port_rdy && !dx_rdy && (st == S_IDLE)
    |=> !port_stb && !dx_stb);
endmodule

// File: tb/mmio_vga_bridge_test.sv
`timescale 1ns/1ps
module mmio_vga_bridge_test;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [2:0]  req_size = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic        port_stb, port_we, port_rdy = 0;
  logic [9:0]  port_addr;
  logic [7:0]  port_wdata, port_rdata = 0;
  logic        dx_stb, dx_index, dx_we, dx_rdy = 0;
  logic [15:0] dx_wdata, dx_rdata = 0;
  logic        xreg_en = 1, big_endian;
  logic [7:0]  revision;

  mmio_vga_bridge uut (.*);

  int tests = 0, fails = 0, lat = 0, pcnt = 0, dcnt = 0;
  logic [4:0] last_idx = 0;
  logic [28:0] expq[$];
  string tagq[$];

  function automatic logic [28:0] enc(int kind, bit we, logic [9:0] a, logic [15:0] d);
    return {2'(kind), we, a, d};
  endfunction
  function automatic logic [7:0] pmodel(logic [9:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction
  function automatic logic [15:0] dmodel(logic [4:0] i);
    return 16'hA000 | 16'(i * 3);
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push_port(bit we, logic [9:0] a, logic [7:0] d, string tag);
    expq.push_back(enc(0, we, a, we ? {8'h0, d} : 16'h0));
    tagq.push_back(tag);
  endtask
  task automatic push_dx(bit we, logic [4:0] i, logic [15:0] d, string tag);
    expq.push_back(enc(1, 1'b1, 10'h0, {11'b0, i}));
    tagq.push_back(tag);
    expq.push_back(enc(2, we, 10'h0, we ? d : 16'h0));
    tagq.push_back(tag);
  endtask

  function automatic void scoreboard(logic [28:0] act);
    string t;
    logic [28:0] e;
    if (expq.size() == 0) begin
      tests++; fails++;
      $display("FAIL unexpected strobe: actual %h expected none", act);
      return;
    end
    e = expq.pop_front();
    t = tagq.pop_front();
    tests++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s downstream transfer: actual %h expected %h", t, act, e);
    end
  endfunction

  always @(negedge clk) begin
    port_rdy = 0;
    dx_rdy = 0;
    if (pcnt > 0) begin pcnt--; if (pcnt == 0) port_rdy = 1; end
    if (dcnt > 0) begin dcnt--; if (dcnt == 0) dx_rdy = 1; end
    if (port_stb) begin
      scoreboard(enc(0, port_we, port_addr, port_we ? {8'h0, port_wdata} : 16'h0));
      port_rdata = pmodel(port_addr);
      if (lat == 0) port_rdy = 1; else pcnt = lat;
    end
    if (dx_stb) begin
      if (dx_index) begin
        scoreboard(enc(1, dx_we, 10'h0, dx_wdata));
        last_idx = dx_wdata[4:0];
      end else begin
        scoreboard(enc(2, dx_we, 10'h0, dx_we ? dx_wdata : 16'h0));
        dx_rdata = dmodel(last_idx);
      end
      if (lat == 0) dx_rdy = 1; else dcnt = lat;
    end
  end

  task automatic access(bit we, logic [11:0] a, logic [2:0] sz, logic [31:0] wdat,
                        logic [31:0] exp, string tag);
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_size = sz; req_wdata = wdat;
    do @(negedge clk); while (!req_ready);
    if (!we) check(req_rdata === exp, tag, "read data", req_rdata, exp);
    req_valid = 0;
    check(expq.size() == 0, tag, "transfers left over", expq.size(), 0);
    expq.delete(); tagq.delete();
    @(negedge clk);
    check(req_ready == 0, "R11", "ready width", req_ready, 0);
  endtask

  initial begin
    #(8 * 100000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 0 && port_stb == 0 && dx_stb == 0, "R12", "idle outputs",
          {req_ready, port_stb, dx_stb}, 0);
    check(big_endian == 0, "R12", "byte order after reset", big_endian, 0);
    rst_n = 1;
    @(negedge clk);
    check(revision == 8'd2, "R9", "revision enabled", revision, 2);

    // R1 single byte write and read at region edges
    push_port(1, 10'h3C4, 8'h77, "R1");
    access(1, 12'h404, 1, 32'h77, 0, "R1");
    push_port(0, 10'h3DF, 0, "R1");
    access(0, 12'h41F, 1, 0, {24'h0, pmodel(10'h3DF)}, "R1");

    // R2 16-bit write low byte first
    push_port(1, 10'h3D4, 8'h12, "R2");
    push_port(1, 10'h3D5, 8'hAB, "R2");
    access(1, 12'h414, 2, 32'h0000AB12, 0, "R2");

    // R3 16-bit read assembly
    push_port(0, 10'h3C0, 0, "R3");
    push_port(0, 10'h3C1, 0, "R3");
    access(0, 12'h400, 2, 0, {16'h0, pmodel(10'h3C1), pmodel(10'h3C0)}, "R3");

    // R4 32-bit accesses with responder delay
    lat = 2;
    push_port(1, 10'h3DC, 8'h11, "R4");
    push_port(1, 10'h3DD, 8'h22, "R4");
    push_port(1, 10'h3DE, 8'h33, "R4");
    push_port(1, 10'h3DF, 8'h44, "R4");
    access(1, 12'h41C, 4, 32'h44332211, 0, "R4");
    for (int k = 0; k < 4; k++) push_port(0, 10'(10'h3C8 + k), 0, "R4");
    access(0, 12'h408, 4, 0, {pmodel(10'h3CB), pmodel(10'h3CA), pmodel(10'h3C9), pmodel(10'h3C8)}, "R4");
    lat = 0;

    // R10 access running past the port region, bad size, unmapped
    access(0, 12'h41E, 4, 0, 0, "R10");
    access(0, 12'h404, 3, 0, 0, "R10");
    access(1, 12'h700, 4, 32'hFFFFFFFF, 0, "R10");
    access(0, 12'h000, 4, 0, 0, "R10");

    // R5 indexed interface
    push_dx(1, 5'd5, 16'h1234, "R5");
    access(1, 12'h50A, 2, 32'h99991234, 0, "R5");
    lat = 1;
    push_dx(0, 5'd10, 0, "R5");
    access(0, 12'h514, 2, 0, {16'h0, dmodel(5'd10)}, "R5");
    lat = 0;
    access(0, 12'h516, 2, 0, 0, "R10");

    // R6 R7 R8 extension registers
    access(0, 12'h600, 4, 0, 32'd8, "R6");
    access(0, 12'h600, 2, 0, 0, "R6");
    access(0, 12'h604, 4, 0, 32'h1E1E1E1E, "R7");
    access(1, 12'h604, 4, 32'hBEBEBEBE, 0, "R8");
    check(big_endian == 1, "R7", "big_endian output", big_endian, 1);
    access(0, 12'h604, 4, 0, 32'hBEBEBEBE, "R7");
    access(1, 12'h604, 4, 32'h12345678, 0, "R8");
    access(0, 12'h604, 4, 0, 32'hBEBEBEBE, "R8");
    access(1, 12'h600, 4, 32'h1E1E1E1E, 0, "R8");
    access(0, 12'h604, 4, 0, 32'hBEBEBEBE, "R8");
    access(1, 12'h604, 4, 32'h1E1E1E1E, 0, "R8");
    access(0, 12'h604, 4, 0, 32'h1E1E1E1E, "R8");

    // R9 disabled extension registers
    xreg_en = 0;
    @(negedge clk);
    check(revision == 8'd1, "R9", "revision disabled", revision, 1);
    access(0, 12'h600, 4, 0, 0, "R9");
    access(1, 12'h604, 4, 32'hBEBEBEBE, 0, "R9");
    check(big_endian == 0, "R9", "write ignored while disabled", big_endian, 0);
    xreg_en = 1;
    access(0, 12'h604, 4, 0, 32'h1E1E1E1E, "R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule